// File: doc/BRIEF.md
# Instruction Byte Prefetch Queue

This block keeps a short first-in, first-out store of code bytes between a bus fetch path and an execution unit. While the execution unit is busy with the current instruction, the block reads the next sequential code words from memory on its own and holds the bytes in order. A byte that is already held is offered to the execution unit at once, without waiting for memory. Fetch and execute therefore overlap.

Memory is read one 16-bit word per request over a request/ready port. Only one request is outstanding at a time. A fetch at an even address yields two bytes. A fetch at an odd address can only happen as the first fetch after a redirect to an odd target, and it yields one byte. The execution unit pulls bytes through a valid/ready handshake. It can hold the bus for its own data traffic through a single busy input. On a taken jump or call it raises a flush with the new target address. The flush empties the store, turns any read still in flight into a stale read whose data is dropped, and restarts fetching at the target.

Top module: `ifq_prefetch`

## Requirements
- R1: After reset the store is empty, `ex_valid` and `mem_req` are low, and the first fetch uses address `RESET_ADDR`.
- R2: The store never holds more than `DEPTH` bytes (default 6).
- R3: Bytes reach the execution unit in the order they were fetched. The byte at the head stays on `ex_byte` with `ex_valid` high until it is popped or flushed.
- R4: A completed fetch whose address bit 0 is 0 appends two bytes: first `mem_rdata[7:0]` (the byte at that address), then `mem_rdata[15:8]`. A completed fetch at an odd address appends only `mem_rdata[15:8]`.
- R5: A request is raised only while none is outstanding. It also requires that, at the deciding clock edge, `bus_busy` and `flush` were low and at least two slots were free (one slot if the fetch pointer is odd). `mem_addr` then equals the fetch pointer.
- R6: Once raised, `mem_req` stays high with `mem_addr` unchanged until a cycle with `mem_ready` high. That cycle completes the read.
- R7: `flush` empties the store, so `ex_valid` is low in the next cycle. It also loads the fetch pointer with `flush_addr`.
- R8: If a read is outstanding when `flush` is raised, its data is dropped when it completes. Data completing in the flush cycle itself is dropped too.
- R9: When `flush` and a pop (`ex_valid` and `ex_ready`) fall in the same cycle, the flush wins and the store is empty afterwards.
- R10: `ex_valid` is high exactly when the store holds a byte. A completed fetch and a pop in the same cycle are both applied.
- R11: After each accepted fetch the fetch pointer advances by the number of bytes appended (two, or one for an odd address).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Taken jump/call: discard the store and redirect fetching |
| flush_addr | input | ADDR_W | New program address used on flush |
| bus_busy | input | 1 | Execution unit holds the bus; no new fetch may start |
| mem_req | output | 1 | Word read request, held until `mem_ready` |
| mem_addr | output | ADDR_W | Byte address of the fetch; memory returns the word containing it |
| mem_ready | input | 1 | Read completes in this cycle |
| mem_rdata | input | 16 | Read word; bits 7:0 hold the even byte |
| ex_valid | output | 1 | A byte is available at `ex_byte` |
| ex_byte | output | 8 | Head byte of the store |
| ex_ready | input | 1 | Execution unit takes the head byte |

## Verification
The bench targets four corner cases.

- Redirect while a read is still outstanding. A design that lost the stale mark would slip bytes from the old path ahead of the target's first byte.
- Redirect to an odd target. Here the first fetch must append only the upper byte; getting it wrong duplicates or swaps a byte and shifts the whole stream.
- A store one slot short of full. An off-by-one space test would push a word into a single free slot and overwrite the head.
- Flush in the same cycle as a pop, and a completion in the same cycle as a pop. Wrong priority or lost updates show up as `ex_valid` staying high after the flush, or as a skipped or repeated byte.

// File: rtl/ifq_pkg.sv
package ifq_pkg;
  localparam int unsigned WORD_BYTES = 2;

  // number of bytes a fetch at this address delivers into the store
  function automatic logic [1:0] bytes_for(input logic odd);
    return odd ? 2'd1 : 2'd2;
  endfunction
endpackage

// File: rtl/ifq_store.sv
module ifq_store #(
  parameter int unsigned DEPTH = 6,
  parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic [1:0]       push_n,
  input  logic [7:0]       push_b0,
  input  logic [7:0]       push_b1,
  input  logic             pop,
  output logic [7:0]       head,
  output logic             valid,
  output logic [CNT_W-1:0] count
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [7:0]       slots [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [PTR_W-1:0] wr_p1, wr_p2;

  function automatic logic [PTR_W-1:0] step_ptr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign wr_p1 = step_ptr(wr_ptr);
  assign wr_p2 = step_ptr(wr_p1);

  // storage without reset so it can map onto distributed memory
  always_ff @(posedge clk) begin
    if (!clear && push_n != 2'd0) slots[wr_ptr] <= push_b0;
    if (!clear && push_n == 2'd2) slots[wr_p1]  <= push_b1;
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (pop) rd_ptr <= step_ptr(rd_ptr);
      case (push_n)
        2'd1:    wr_ptr <= wr_p1;
        2'd2:    wr_ptr <= wr_p2;
        default: wr_ptr <= wr_ptr;
      endcase
      count <= count + CNT_W'(push_n) - CNT_W'(pop);
    end
  end

  assign head  = slots[rd_ptr];
  assign valid = (count != '0);
endmodule

// File: rtl/ifq_fetch.sv
module ifq_fetch
  import ifq_pkg::*;
#(
  parameter int unsigned    ADDR_W     = 20,
  parameter int unsigned    DEPTH      = 6,
  parameter int unsigned    CNT_W      = $clog2(DEPTH + 1),
  parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic [ADDR_W-1:0] flush_addr,
  input  logic              bus_busy,
  input  logic [CNT_W-1:0]  count,
  input  logic              mem_ready,
  input  logic [15:0]       mem_rdata,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [1:0]        push_n,
  output logic [7:0]        push_b0,
  output logic [7:0]        push_b1
);
  logic [ADDR_W-1:0] fptr;
  logic              stale;
  logic [CNT_W-1:0]  free_slots;
  logic [1:0]        need;
  logic              issue, done, accept;

  assign free_slots = CNT_W'(DEPTH) - count;
  assign need       = bytes_for(fptr[0]);
  assign issue      = !mem_req && !flush && !bus_busy && (free_slots >= CNT_W'(need));
  assign done       = mem_req && mem_ready;
  assign accept     = done && !stale && !flush;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_req  <= 1'b0;
      mem_addr <= '0;
      fptr     <= RESET_ADDR;
      stale    <= 1'b0;
    end else begin
      if (done) begin
        mem_req <= 1'b0;
        stale   <= 1'b0;
      end else if (issue) begin
        mem_req  <= 1'b1;
        mem_addr <= fptr;
      end
      if (flush) begin
        fptr <= flush_addr;
        if (mem_req && !mem_ready) stale <= 1'b1;
      end else if (accept) begin
        fptr <= fptr + ADDR_W'(bytes_for(mem_addr[0]));
      end
    end
  end

  assign push_n  = accept ? bytes_for(mem_addr[0]) : 2'd0;
  assign push_b0 = mem_addr[0] ? mem_rdata[15:8] : mem_rdata[7:0];
  assign push_b1 = mem_rdata[15:8];
endmodule

// File: rtl/ifq_prefetch.sv
module ifq_prefetch #(
  parameter int unsigned       ADDR_W     = 20,
  parameter int unsigned       DEPTH      = 6,
  parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic [ADDR_W-1:0] flush_addr,
  input  logic              bus_busy,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ready,
  input  logic [15:0]       mem_rdata,
  output logic              ex_valid,
  output logic [7:0]        ex_byte,
  input  logic              ex_ready
);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [CNT_W-1:0] fill_count;
  logic [1:0]       push_n;
  logic [7:0]       push_b0, push_b1;
  logic             pop;

  assign pop = ex_valid && ex_ready;

  ifq_fetch #(
    .ADDR_W(ADDR_W), .DEPTH(DEPTH), .CNT_W(CNT_W), .RESET_ADDR(RESET_ADDR)
  ) u_fetch (
    .clk(clk), .rst(rst), .flush(flush), .flush_addr(flush_addr),
    .bus_busy(bus_busy), .count(fill_count), .mem_ready(mem_ready),
    .mem_rdata(mem_rdata), .mem_req(mem_req), .mem_addr(mem_addr),
    .push_n(push_n), .push_b0(push_b0), .push_b1(push_b1)
  );

  ifq_store #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_store (
    .clk(clk), .rst(rst), .clear(flush), .push_n(push_n),
    .push_b0(push_b0), .push_b1(push_b1), .pop(pop),
    .head(ex_byte), .valid(ex_valid), .count(fill_count)
  );
endmodule

// File: rtl/ifq_prefetch_chk.sv
module ifq_prefetch_chk #(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned DEPTH  = 6,
  parameter int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              flush,
  input logic              bus_busy,
  input logic              mem_req,
  input logic              mem_ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              ex_valid,
  input logic              ex_ready,
  input logic [7:0]        ex_byte,
  input logic [CNT_W-1:0]  fill_count
);
  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (rst)
    fill_count <= CNT_W'(DEPTH));

  assert_req_hold_R6: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr));

  assert_issue_gate_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_req) |-> $past(!bus_busy && !flush));

  assert_flush_empties_R7: assert property (@(posedge clk) disable iff (rst)
    flush |=> !ex_valid);

  assert_flush_beats_pop_R9: assert property (@(posedge clk) disable iff (rst)
    flush && ex_valid && ex_ready |=> fill_count == '0);

  assert_head_hold_R3: assert property (@(posedge clk) disable iff (rst)
    ex_valid && !ex_ready && !flush |=> ex_valid && $stable(ex_byte));
endmodule

bind ifq_prefetch ifq_prefetch_chk #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .flush(flush), .bus_busy(bus_busy),
  .mem_req(mem_req), .mem_ready(mem_ready), .mem_addr(mem_addr),
  .ex_valid(ex_valid), .ex_ready(ex_ready), .ex_byte(ex_byte),
  .fill_count(fill_count)
);

// File: tb/sim_ifq_prefetch.sv
module sim_ifq_prefetch;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 20;
  localparam int DEPTH = 6;

  logic clk = 1'b0, rst = 1'b1;
  logic flush = 0, bus_busy = 0, mem_ready = 0, ex_ready = 0;
  logic [AW-1:0] flush_addr = '0;
  logic [15:0] mem_rdata = '0;
  logic mem_req, ex_valid;
  logic [AW-1:0] mem_addr;
  logic [7:0] ex_byte;

  int checks = 0, fails = 0;
  bit finished = 0;

  // reference model state
  byte unsigned q[$];
  logic [AW-1:0] m_fptr;
  bit m_stale, prev_req, prev_wait, prev_busy, prev_flush;
  logic [AW-1:0] prev_addr;
  int prev_size;

  ifq_prefetch #(.ADDR_W(AW), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst(rst), .flush(flush), .flush_addr(flush_addr),
    .bus_busy(bus_busy), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata), .ex_valid(ex_valid),
    .ex_byte(ex_byte), .ex_ready(ex_ready)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic byte unsigned memb(input logic [AW-1:0] a);
    return 8'(a * 13 + (a >> 8) * 7 + 5);
  endfunction

  function automatic logic [15:0] memw(input logic [AW-1:0] a);
    logic [AW-1:0] e;
    e = {a[AW-1:1], 1'b0};
    return {memb(e + 1), memb(e)};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // called at a falling edge: compare, drive, update model, wait one cycle
  task automatic step(input bit fl, input logic [AW-1:0] tgt, input bit busy,
                      input bit rdy, input bit mrdy);
    bit complete;
    int need;
    chk(ex_valid == (q.size() != 0), "R10", "ex_valid vs occupancy", ex_valid, q.size() != 0);
    if (q.size() != 0) chk(ex_byte == q[0], "R3", "head byte", ex_byte, q[0]);
    if (mem_req && !prev_req) begin
      need = mem_addr[0] ? 1 : 2;
      chk(mem_addr == m_fptr, "R11", "fetch address", mem_addr, m_fptr);
      chk(!prev_busy && !prev_flush, "R5", "issue while busy/flush", {prev_busy, prev_flush}, 0);
      chk(prev_size + need <= DEPTH, "R5", "free space at issue", prev_size + need, DEPTH);
    end
    if (prev_wait) chk(mem_req && mem_addr == prev_addr, "R6", "request held", mem_addr, prev_addr);

    flush = fl; flush_addr = tgt; bus_busy = busy; ex_ready = rdy;
    mem_ready = mrdy & mem_req;
    mem_rdata = memw(mem_addr);
    complete = mem_req && mem_ready;

    prev_size  = q.size();
    prev_busy  = busy;
    prev_flush = fl;
    prev_req   = mem_req;
    prev_wait  = mem_req && !mem_ready;
    prev_addr  = mem_addr;

    if (fl) begin
      q.delete();
      if (mem_req && !mem_ready) m_stale = 1;
      if (complete) m_stale = 0;
      m_fptr = tgt;
    end else begin
      if (q.size() != 0 && rdy) void'(q.pop_front());
      if (complete) begin
        if (m_stale) m_stale = 0;
        else if (mem_addr[0]) begin
          q.push_back(memb(mem_addr));
          m_fptr = m_fptr + 1;
        end else begin
          q.push_back(memb(mem_addr));
          q.push_back(memb(mem_addr + 1));
          m_fptr = m_fptr + 2;
        end
        chk(q.size() <= DEPTH, "R2", "occupancy bound", q.size(), DEPTH);
      end
    end
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    m_fptr = '0; m_stale = 0; prev_req = 0; prev_wait = 0;
    prev_busy = 0; prev_flush = 0; prev_size = 0; prev_addr = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset state
    chk(!ex_valid, "R1", "ex_valid after reset", ex_valid, 0);
    chk(!mem_req, "R1", "mem_req after reset", mem_req, 0);

    // R2 / R4 / R1: fill with no pops, first fetch from reset address
    for (int i = 0; i < 20; i++) step(0, '0, 0, 0, 1);
    chk(q.size() == DEPTH && ex_valid, "R2", "store full", q.size(), DEPTH);
    chk(!mem_req, "R5", "no request when full", mem_req, 0);
    chk(ex_byte == memb('0), "R1", "first byte from reset address", ex_byte, memb('0));

    // R9: flush and pop in the same cycle
    step(1, 20'h500, 0, 1, 0);
    chk(!ex_valid, "R9", "empty after flush+pop", ex_valid, 0);

    // R5: bus held by execution unit
    step(1, 20'h100, 1, 0, 1);
    for (int i = 0; i < 8; i++) begin
      step(0, '0, 1, 0, 1);
      chk(!mem_req, "R5", "no request while bus busy", mem_req, 0);
    end
    for (int i = 0; i < 10; i++) step(0, '0, 0, 1, 1);

    // R4 / R11: odd target yields a single upper byte first
    step(1, 20'h201, 0, 0, 1);
    for (int i = 0; i < 6; i++) step(0, '0, 0, 0, 1);
    chk(ex_valid && ex_byte == memb(20'h201), "R4", "odd target first byte", ex_byte, memb(20'h201));
    step(0, '0, 0, 1, 1);
    chk(ex_byte == memb(20'h202), "R4", "byte after odd fetch", ex_byte, memb(20'h202));

    // R8: flush while a read is outstanding
    step(1, 20'h300, 0, 0, 0);
    for (int i = 0; i < 10 && !mem_req; i++) step(0, '0, 0, 0, 0);
    chk(mem_req, "R6", "request pending before redirect", mem_req, 1);
    step(1, 20'h401, 0, 0, 0);
    step(0, '0, 0, 0, 1);
    for (int i = 0; i < 8; i++) step(0, '0, 0, 0, 1);
    chk(ex_valid && ex_byte == memb(20'h401), "R8", "stale data dropped", ex_byte, memb(20'h401));

    // R10: pops and completions overlapping
    for (int i = 0; i < 40; i++) step(0, '0, 0, 1, 1);

    // randomized mix
    for (int i = 0; i < 6000; i++) begin
      bit fl = ($urandom_range(0, 29) == 0);
      step(fl, AW'($urandom), ($urandom_range(0, 3) == 0),
           ($urandom_range(0, 2) != 0), ($urandom_range(0, 2) != 0));
    end
    for (int i = 0; i < 4; i++) step(0, '0, 0, 0, 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule